// File: doc/BRIEF.md
# Banked Work RAM Controller

This block serves an 8-bit CPU bus that has a 16-bit address. It decodes accesses to a work-RAM region and turns them into reads and writes of an internal synchronous byte store. The region has two 4 KB windows. The lower window (0xC000–0xCFFF) always shows page 0 of the store. The upper window (0xD000–0xDFFF) shows whichever page a bank register selects. The CPU writes and reads the bank register at I/O address 0xFF70. The span from 0xE000 to 0xFDFF is a mirror of the two windows.

A mode input chooses between two configurations:

- **Banked mode:** all pages of the store are reachable.
- **Compatibility mode:** the store shrinks to its first two pages and banking is off, so the upper window always shows page 1.

The page size is a parameter, `PAGE_AW` (address bits per page):

- A full-size build uses `PAGE_AW = 12`, which gives 4 KB pages and a 32 KB store.
- A reduced build uses fewer bits, and each window then aliases its page.

Reads return data one cycle after the strobe, and a read-valid flag marks them.

Top module: `wram_bank_ctrl`

## Requirements
- R1: After reset the selected bank is 1, `cpu_rvalid` is 0, and `cpu_rdata` is 0x00 whenever `cpu_rvalid` is 0.
- R2: An access in 0xC000–0xCFFF reaches store index `addr[PAGE_AW-1:0]`, which is page 0.
- R3: An access in 0xD000–0xDFFF reaches store index `bank * 2^PAGE_AW + addr[PAGE_AW-1:0]`, where bank is the effective bank.
- R4: In banked mode, a write to 0xFF70 loads `wdata[2:0]` into the bank register. Bits [7:3] have no effect.
- R5: A bank value of 0 written to 0xFF70 is stored as 1, so the bank register never holds 0.
- R6: A read of 0xFF70 returns the effective bank in bits [2:0], with bits [7:3] read as 1.
- R7: In compatibility mode (`banked_mode = 0`), writes to 0xFF70 leave the bank register unchanged. The effective bank is 1 and reads back as 0xF9. The stored bank value is still in force when banked mode returns.
- R8: An address in 0xE000–0xFDFF behaves exactly like the address 0x2000 lower, and uses the current bank.
- R9: A bank change takes effect on the very next access after the register write.
- R10: `cpu_rvalid` rises in the cycle after a read strobe to a claimed address (0xC000–0xFDFF or 0xFF70), together with its data. All other addresses give no `cpu_rvalid` and leave the store and the bank register unchanged.
- R11: A byte written to a store location is returned by a later read of that location. Each page holds its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| banked_mode | input | 1 | 1 = banked mode, 0 = compatibility mode |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data, valid when cpu_rvalid is 1 |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |

## Verification
The same upper-window offset is written under each of the seven banks and then read back under each selection. This separates a correct page selection from one that ignores the bank or aliases pages together. Bank writes are made with junk in bits [7:3], and with a value of zero, so that masking is told apart from the zero-to-one substitution.

Mirror accesses are interleaved with accesses to the direct windows. This shows that the mirror follows the live bank selection and not a fixed page. In compatibility mode the bench writes the bank register, then returns to banked mode. This shows both that the write was ignored and that data written in that mode lands on page 1. Writes to unclaimed addresses are followed by reads of the store locations they would alias, which exposes decode leaks.

// File: rtl/wram_pkg.sv
package wram_pkg;
  typedef enum logic [1:0] {
    TGT_NONE    = 2'd0,
    TGT_LOW     = 2'd1,
    TGT_HIGH    = 2'd2,
    TGT_BANKREG = 2'd3
  } tgt_e;

  localparam logic [15:0] BANKREG_ADDR = 16'hFF70;
  localparam logic [15:0] MIRROR_END   = 16'hFDFF;
endpackage

// File: rtl/wram_addr_decode.sv
module wram_addr_decode
  import wram_pkg::*;
#(
  parameter int PAGE_AW = 8
) (
  input  logic [15:0]        addr,
  output tgt_e               tgt,
  output logic [PAGE_AW-1:0] page_off
);
  // The 4 KB region nibble picks the window; the mirror repeats C/D at E/F.
  always_comb begin
    tgt = TGT_NONE;
    unique case (addr[15:12])
      4'hC, 4'hE: tgt = TGT_LOW;
      4'hD:       tgt = TGT_HIGH;
      4'hF: begin
        if (addr <= MIRROR_END)        tgt = TGT_HIGH;
        else if (addr == BANKREG_ADDR) tgt = TGT_BANKREG;
        else                           tgt = TGT_NONE;
      end
      default:    tgt = TGT_NONE;
    endcase
  end

  assign page_off = addr[PAGE_AW-1:0];
endmodule

// File: rtl/wram_bank_reg.sv
module wram_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              banked,
  input  logic              load,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0] bank_eff
);
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic              bank_en;
  logic [BANK_W-1:0] bank_d;

  // Loads happen only in banked mode; a zero selection is replaced by one.
  always_comb begin
    bank_en = load & banked;
    bank_d  = (load_val == '0) ? BANK_ONE : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= BANK_ONE;
    else if (bank_en) bank_q <= bank_d;
  end

  assign bank_eff = banked ? bank_q : BANK_ONE;
endmodule

// File: rtl/wram_store.sv
module wram_store #(
  parameter int AW    = 11,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata_q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[idx];
  end
endmodule

// File: rtl/wram_bank_ctrl.sv
module wram_bank_ctrl
  import wram_pkg::*;
#(
  parameter int PAGE_AW   = 8,
  parameter int NUM_BANKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        banked_mode,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_rvalid
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = BANK_W + PAGE_AW;
  localparam int DEPTH  = NUM_BANKS << PAGE_AW;
  localparam int PAD_W  = 8 - BANK_W;

  tgt_e               tgt;
  logic [PAGE_AW-1:0] page_off;
  logic [BANK_W-1:0]  bank_q;
  logic [BANK_W-1:0]  bank_eff;
  logic [BANK_W-1:0]  page_sel;
  logic [IDX_W-1:0]   store_idx;
  logic               is_mem;
  logic               mem_we;
  logic               mem_re;
  logic               reg_we;
  logic [7:0]         mem_rdata;

  logic               rvalid_d, rvalid_q;
  logic               regsel_d, regsel_q;
  logic [7:0]         bankrd_d, bankrd_q;
  logic               rd_en;

  wram_addr_decode #(.PAGE_AW(PAGE_AW)) dec_i (
    .addr     (cpu_addr),
    .tgt      (tgt),
    .page_off (page_off)
  );

  wram_bank_reg #(.BANK_W(BANK_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .banked   (banked_mode),
    .load     (reg_we),
    .load_val (cpu_wdata[BANK_W-1:0]),
    .bank_q   (bank_q),
    .bank_eff (bank_eff)
  );

  always_comb begin
    is_mem    = (tgt == TGT_LOW) || (tgt == TGT_HIGH);
    mem_we    = cpu_wr & is_mem;
    mem_re    = cpu_rd & is_mem;
    reg_we    = cpu_wr & (tgt == TGT_BANKREG);
    page_sel  = (tgt == TGT_HIGH) ? bank_eff : '0;
    store_idx = {page_sel, page_off};
  end

  wram_store #(.AW(IDX_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .we      (mem_we),
    .re      (mem_re),
    .idx     (store_idx),
    .wdata   (cpu_wdata),
    .rdata_q (mem_rdata)
  );

  // Read-return pipeline: next state.
  always_comb begin
    rvalid_d = cpu_rd & (tgt != TGT_NONE);
    regsel_d = (tgt == TGT_BANKREG);
    bankrd_d = {{PAD_W{1'b1}}, bank_eff};
    rd_en    = cpu_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regsel_q <= 1'b0;
      bankrd_q <= 8'h00;
    end else if (rd_en) begin
      regsel_q <= regsel_d;
      bankrd_q <= bankrd_d;
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = !rvalid_q ? 8'h00 : (regsel_q ? bankrd_q : mem_rdata);
endmodule

// File: rtl/wram_bank_ctrl_chk.sv
module wram_bank_ctrl_chk #(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              banked_mode,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_rdata,
  input logic              cpu_rvalid,
  input logic [BANK_W-1:0] bank_q
);
  // R5
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != '0);

  // R10
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_rd));

  // R6
  readback_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid && $past(cpu_addr) == 16'hFF70) |-> (&cpu_rdata[7:BANK_W]));

  // R7
  compat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!banked_mode && cpu_wr && cpu_addr == 16'hFF70) |=> $stable(bank_q));

  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_mode && cpu_wr && cpu_addr == 16'hFF70 && cpu_wdata[BANK_W-1:0] != '0)
      |=> bank_q == $past(cpu_wdata[BANK_W-1:0]));

  // R1
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rvalid |-> cpu_rdata == 8'h00);
endmodule

bind wram_bank_ctrl wram_bank_ctrl_chk #(.BANK_W(BANK_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .banked_mode (banked_mode),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_rd      (cpu_rd),
  .cpu_wr      (cpu_wr),
  .cpu_rdata   (cpu_rdata),
  .cpu_rvalid  (cpu_rvalid),
  .bank_q      (bank_q)
);

// File: tb/wram_bank_ctrl_tb_top.sv
module wram_bank_ctrl_tb_top;
  localparam int PAGE_AW = 8;
  localparam int PAGE    = 1 << PAGE_AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        banked_mode;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0] ref_mem [8*PAGE];
  int         bank_m;

  always #2 clk = ~clk;

  wram_bank_ctrl #(.PAGE_AW(PAGE_AW), .NUM_BANKS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .banked_mode(banked_mode),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Model index from the requirements (R2, R3, R8).
  function automatic int model_idx(input logic [15:0] a);
    logic [15:0] d;
    int eb;
    d  = (a >= 16'hE000) ? a - 16'h2000 : a;
    eb = banked_mode ? bank_m : 1;
    return (d[15:12] == 4'hC) ? int'(a[7:0]) : eb * PAGE + int'(a[7:0]);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a >= 16'hC000 && a <= 16'hFDFF) ref_mem[model_idx(a)] = v;
    if (a == 16'hFF70 && banked_mode) bank_m = (v[2:0] == 0) ? 1 : int'(v[2:0]);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check(cpu_rvalid === 1'b1, req, cpu_rvalid, 1);
    check(cpu_rdata === exp, req, cpu_rdata, exp);
  endtask

  task automatic rd_mem(input logic [15:0] a, input string req);
    rd(a, ref_mem[model_idx(a)], req);
  endtask

  task automatic t_reset();
    check(cpu_rvalid === 1'b0, "R1 rvalid", cpu_rvalid, 0);
    check(cpu_rdata === 8'h00, "R1 rdata", cpu_rdata, 0);
    rd(16'hFF70, 8'hF9, "R1 R6 reset bank");
  endtask

  task automatic t_low();
    wr(16'hC000, 8'hA5);
    wr(16'hC0FF, 8'h5A);
    wr(16'hC012, 8'h3C);
    rd_mem(16'hC000, "R2 R11 low first");
    rd_mem(16'hC0FF, "R2 R11 low last");
    rd_mem(16'hC012, "R2 R11 low mid");
  endtask

  task automatic t_banks();
    for (int b = 1; b < 8; b++) begin
      wr(16'hFF70, 8'hF8 | 8'(b));
      wr(16'hD020, 8'h40 + 8'(b));
    end
    for (int b = 7; b >= 1; b--) begin
      wr(16'hFF70, 8'(b));
      rd(16'hFF70, 8'hF8 | 8'(b), "R4 R6 readback");
      rd(16'hD020, 8'h40 + 8'(b), "R3 R11 bank data");
    end
    wr(16'hFF70, 8'hF0);
    rd(16'hFF70, 8'hF9, "R5 zero becomes one");
    rd(16'hD020, 8'h41, "R5 bank1 data");
    // R9: read on the cycle right after the bank write
    wr(16'hFF70, 8'h06);
    rd(16'hD020, 8'h46, "R9 immediate effect");
  endtask

  task automatic t_mirror();
    wr(16'hE030, 8'h9E);
    rd(16'hC030, 8'h9E, "R8 mirror low");
    wr(16'hFF70, 8'h03);
    wr(16'hF040, 8'h33);
    rd(16'hD040, 8'h33, "R8 mirror high bank3");
    wr(16'hFF70, 8'h05);
    wr(16'hD040, 8'h55);
    rd(16'hF040, 8'h55, "R8 mirror follows bank5");
    rd(16'hFDFF, ref_mem[model_idx(16'hFDFF)] === 8'hxx ? 8'h00 : ref_mem[model_idx(16'hFDFF)], "R8 mirror top");
  endtask

  task automatic t_compat();
    wr(16'hFF70, 8'h04);
    @(negedge clk);
    banked_mode = 1'b0;
    wr(16'hFF70, 8'h06);
    rd(16'hFF70, 8'hF9, "R7 compat readback");
    wr(16'hD050, 8'h77);
    rd(16'hD050, 8'h77, "R7 compat data");
    @(negedge clk);
    banked_mode = 1'b1;
    rd(16'hFF70, 8'hFC, "R7 bank kept");
    wr(16'hFF70, 8'h01);
    rd(16'hD050, 8'h77, "R7 compat used page1");
  endtask

  task automatic t_unclaimed();
    wr(16'hC060, 8'h12);
    wr(16'hA060, 8'hEE);
    wr(16'hFE60, 8'hEE);
    wr(16'hFF71, 8'h07);
    rd(16'hC060, 8'h12, "R10 store untouched");
    rd(16'hFF70, 8'hF9, "R10 bank untouched");
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check(cpu_rvalid === 1'b0, "R10 no rvalid", cpu_rvalid, 0);
    check(cpu_rdata === 8'h00, "R10 R1 idle rdata", cpu_rdata, 0);
  endtask

  initial begin
    rst_n = 1'b0; banked_mode = 1'b1; cpu_addr = '0; cpu_wdata = '0;
    cpu_rd = 1'b0; cpu_wr = 1'b0; bank_m = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low();
    t_banks();
    t_mirror();
    t_compat();
    t_unclaimed();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule